// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block sits between an internal bus and an external memory cycle sequencer. Each internal access is compared against six programmable address windows. A window claims an access when its enable bit is set and the upper sixteen address bits agree with its base in every position that its don't-care field leaves significant. The result is a one-hot hit vector and the index of the winning window, both registered, which the sequencer uses to start the external cycle. A write that lands in a write-protected window does not produce a hit. It raises a bus-error flag instead.

Window 0 also serves as a boot-time catch-all. Out of reset its enable bit is clear, and in that state it claims every access inside the expansion region while all the other windows stay silent. Once software sets the window 0 enable bit, every window decodes as programmed. Software configures the windows through a simple 32-bit register write/read port. The same port reaches a pin-group multiplex register, which rejects writes with a bus error when they are not full-word or when they set its reserved bits.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, the hit vector, the index and the error flag are 0. The base, mask and multiplex registers read back as 0.
- R2: While the window 0 enable bit (mask register bit 0) is 0, every access in the expansion region gives hit 0x01 with index 0, even when other windows are enabled and match.
- R3: A window matches when, for every address bit 31..16 whose don't-care bit (mask register bits 31:16) is 0, the address bit equals the base bit (address register bits 31:16). Bits marked 1 are ignored.
- R4: A window whose enable bit is 0 never hits, apart from the case in R2.
- R5: When several windows match, the one with the lowest number wins, and the hit vector stays one-hot.
- R6: A write whose winning window has its protect bit (mask register bit 8) set gives an error flag of 1 and a hit vector of 0. A read of the same window hits normally.
- R7: An access outside the expansion region (default 0x6000_0000 to 0xDFFF_FFFF) gives no hit and no error.
- R8: The hit, index and error outputs appear in the cycle after the access is sampled. A cycle with no valid access produces all zeros.
- R9: The multiplex register at offset 0x60 takes a write only when the size code is 2'b10 (word; 2'b00 is byte, 2'b01 is half) and data bits 11:0 are 0. Any other write to it raises the register error flag for one cycle and leaves the register unchanged.
- R10: The registers of window n are at offsets 12n (address), 12n+4 (mask) and 12n+8 (control). A read returns the stored value one cycle after the read strobe, with unimplemented bits reading 0. Control registers hold all 32 bits.
- R11: Whenever the hit vector is nonzero, the index output equals the position of its set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 2 | Write size code: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| reg_err | output | 1 | Rejected multiplex register write |
| acc_valid | input | 1 | Internal access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Internal access address |
| cs_hit | output | 6 | One-hot selected window |
| cs_idx | output | 3 | Index of the selected window |
| bus_err | output | 1 | Write-protect violation |

## Verification
Window priority and write protection meet in the same cycle when a write lands in an address range covered by two windows, the lower one protected and the higher one not. The bench sets up exactly this overlap and checks that the error flag rises with an empty hit vector. In that case the unprotected higher window must not take the access as a fallback. A read to the same address is then checked to go to the protected window. The global-select behaviour of window 0 also overlaps with normal decoding. It is provoked by enabling window 1 before window 0 and checking that an address inside window 1 still selects window 0.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int DATA_W  = 32;
  localparam int CMP_W   = 16;   // compared upper address bits
  localparam int REG_AW  = 8;
  localparam int STRIDE  = 12;
  localparam int OFS_MSK = 4;
  localparam int OFS_CTL = 8;
  localparam logic [REG_AW-1:0] PMUX_OFS = 8'h60;
  localparam int PMUX_LSB = 12;   // bits below are reserved
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] dont_care;
    logic             wprot;
    logic             enable;
  } win_cfg_t;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter logic [DATA_W-1:0] CTRL_RST = 32'h003F_FC00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [1:0]           reg_size,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_err,
  output win_cfg_t             cfg [NUM_WIN]
);
  localparam int PMUX_W = DATA_W - PMUX_LSB;

  win_cfg_t          win_q  [NUM_WIN];
  logic [DATA_W-1:0] ctrl_q [NUM_WIN];
  logic [PMUX_W-1:0] pmux_q;
  logic [DATA_W-1:0] rd_mux;
  logic              pmux_hit, pmux_ok;

  assign pmux_hit = (reg_addr == PMUX_OFS);
  assign pmux_ok  = (reg_size == SIZE_WORD) && (reg_wdata[PMUX_LSB-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        win_q[i]  <= '0;
        ctrl_q[i] <= CTRL_RST;
      end
      pmux_q  <= '0;
      reg_err <= 1'b0;
    end else begin
      reg_err <= reg_we && pmux_hit && !pmux_ok;
      if (reg_we) begin
        for (int i = 0; i < NUM_WIN; i++) begin
          if (reg_addr == REG_AW'(i*STRIDE))
            win_q[i].base <= reg_wdata[DATA_W-1 -: CMP_W];
          if (reg_addr == REG_AW'(i*STRIDE + OFS_MSK)) begin
            win_q[i].dont_care <= reg_wdata[DATA_W-1 -: CMP_W];
            win_q[i].wprot     <= reg_wdata[8];
            win_q[i].enable    <= reg_wdata[0];
          end
          if (reg_addr == REG_AW'(i*STRIDE + OFS_CTL))
            ctrl_q[i] <= reg_wdata;
        end
        if (pmux_hit && pmux_ok)
          pmux_q <= reg_wdata[DATA_W-1:PMUX_LSB];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_addr == REG_AW'(i*STRIDE))
        rd_mux = {win_q[i].base, 16'h0000};
      if (reg_addr == REG_AW'(i*STRIDE + OFS_MSK))
        rd_mux = {win_q[i].dont_care, 7'd0, win_q[i].wprot, 7'd0, win_q[i].enable};
      if (reg_addr == REG_AW'(i*STRIDE + OFS_CTL))
        rd_mux = ctrl_q[i];
    end
    if (pmux_hit)
      rd_mux = {pmux_q, {PMUX_LSB{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assign cfg = win_q;

  // R9: a non-word write to the multiplex register is flagged next cycle
  p_pmux_size_err_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && pmux_hit && reg_size != SIZE_WORD) |=> reg_err);
  // R9: the flag never rises without a write to the multiplex register
  p_pmux_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && pmux_hit) |=> !reg_err);
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter logic [DATA_W-1:0] REGION_LO = 32'h6000_0000,
  parameter logic [DATA_W-1:0] REGION_HI = 32'hDFFF_FFFF
) (
  input  logic [DATA_W-1:0] acc_addr,
  input  win_cfg_t          cfg [NUM_WIN],
  output logic              in_region,
  output logic              global_mode,
  output logic [NUM_WIN-1:0] match_vec,
  output logic [NUM_WIN-1:0] wprot_vec
);
  logic [CMP_W-1:0] tag;

  assign tag         = acc_addr[DATA_W-1 -: CMP_W];
  assign in_region   = (acc_addr >= REGION_LO) && (acc_addr <= REGION_HI);
  assign global_mode = !cfg[0].enable;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic cmp_ok;
    assign cmp_ok = (((tag ^ cfg[w].base) & ~cfg[w].dont_care) == '0) && cfg[w].enable;
    assign wprot_vec[w] = cfg[w].wprot && cfg[w].enable;
    if (w == 0) begin : g_global
      assign match_vec[w] = in_region && (global_mode || cmp_ok);
    end else begin : g_normal
      assign match_vec[w] = in_region && !global_mode && cmp_ok;
    end
  end
endmodule

// File: rtl/cs_select.sv
module cs_select
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  localparam int IDX_W = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               in_region,
  input  logic               global_mode,
  input  logic [NUM_WIN-1:0] match_vec,
  input  logic [NUM_WIN-1:0] wprot_vec,
  output logic [NUM_WIN-1:0] cs_hit,
  output logic [IDX_W-1:0]   cs_idx,
  output logic               bus_err
);
  logic [IDX_W-1:0]   win_idx;
  logic               any_match;
  logic [NUM_WIN-1:0] win_onehot;
  logic               blocked;

  always_comb begin
    win_idx   = '0;
    any_match = 1'b0;
    for (int i = NUM_WIN-1; i >= 0; i--) begin
      if (match_vec[i]) begin
        win_idx   = IDX_W'(i);
        any_match = 1'b1;
      end
    end
    win_onehot = any_match ? (NUM_WIN'(1) << win_idx) : '0;
    blocked    = acc_write && !global_mode && wprot_vec[win_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hit  <= '0;
      cs_idx  <= '0;
      bus_err <= 1'b0;
    end else if (acc_valid && any_match && !blocked) begin
      cs_hit  <= win_onehot;
      cs_idx  <= win_idx;
      bus_err <= 1'b0;
    end else begin
      cs_hit  <= '0;
      cs_idx  <= '0;
      bus_err <= acc_valid && any_match && blocked;
    end
  end

  // R5: never more than one window selected
  p_hit_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(cs_hit));
  // R6: an error never coexists with a selection
  p_err_no_hit_r6: assert property (@(posedge clk) disable iff (rst) bus_err |-> (cs_hit == '0));
  // R2: global mode routes any in-region access to window 0
  p_global_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_region && global_mode) |=> (cs_hit == NUM_WIN'(1)));
  // R7: out-of-region accesses stay silent
  p_outside_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !in_region) |=> (cs_hit == '0 && !bus_err));
  // R8: idle cycles produce nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (cs_hit == '0 && !bus_err));
  // R11: index agrees with the hit vector
  p_idx_r11: assert property (@(posedge clk) disable iff (rst)
    (cs_hit != '0) |-> (cs_hit == (NUM_WIN'(1) << cs_idx)));
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter logic [DATA_W-1:0] REGION_LO = 32'h6000_0000,
  parameter logic [DATA_W-1:0] REGION_HI = 32'hDFFF_FFFF,
  parameter logic [DATA_W-1:0] CTRL_RST  = 32'h003F_FC00,
  localparam int IDX_W = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [1:0]         reg_size,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_err,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [DATA_W-1:0]  acc_addr,
  output logic [NUM_WIN-1:0] cs_hit,
  output logic [IDX_W-1:0]   cs_idx,
  output logic               bus_err
);
  win_cfg_t           cfg [NUM_WIN];
  logic               in_region, global_mode;
  logic [NUM_WIN-1:0] match_vec, wprot_vec;

  cs_regfile #(.NUM_WIN(NUM_WIN), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .cfg(cfg)
  );

  cs_match #(.NUM_WIN(NUM_WIN), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)) u_match (
    .acc_addr(acc_addr), .cfg(cfg), .in_region(in_region),
    .global_mode(global_mode), .match_vec(match_vec), .wprot_vec(wprot_vec)
  );

  cs_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .in_region(in_region), .global_mode(global_mode), .match_vec(match_vec),
    .wprot_vec(wprot_vec), .cs_hit(cs_hit), .cs_idx(cs_idx), .bus_err(bus_err)
  );
endmodule

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0, reg_re = 0;
  logic [7:0]  reg_addr = 0;
  logic [1:0]  reg_size = 2'b10;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        acc_valid = 0, acc_write = 0;
  logic [31:0] acc_addr = 0;
  logic [5:0]  cs_hit;
  logic [2:0]  cs_idx;
  logic        bus_err;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .cs_hit(cs_hit), .cs_idx(cs_idx), .bus_err(bus_err)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [5:0]  hit;
    logic        err;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{32'h7000_0010, 1'b0, 6'h01, 1'b0},  // R3 exact window 0
    '{32'h7001_0000, 1'b0, 6'h00, 1'b0},  // R3 significant bit differs
    '{32'h6013_4567, 1'b1, 6'h02, 1'b0},  // R3 don't-care bits
    '{32'h6018_0000, 1'b0, 6'h02, 1'b0},  // R5 window 1 beats window 2
    '{32'h6020_0000, 1'b0, 6'h00, 1'b0},  // R3 miss
    '{32'h6030_0000, 1'b0, 6'h00, 1'b0},  // R3 unmasked bit 21 differs
    '{32'h8000_0004, 1'b1, 6'h00, 1'b1},  // R6 protected write, w4 not fallback
    '{32'h8000_0004, 1'b0, 6'h08, 1'b0},  // R6 read of protected window
    '{32'h8042_0000, 1'b0, 6'h08, 1'b0},  // R3 wide window
    '{32'h8100_0000, 1'b0, 6'h00, 1'b0},  // R3 beyond mask
    '{32'h9000_0000, 1'b0, 6'h00, 1'b0},  // R4 disabled window 5
    '{32'h1000_0000, 1'b1, 6'h00, 1'b0},  // R7 below region
    '{32'hE000_0000, 1'b0, 6'h00, 1'b0}   // R7 above region
  };

  function automatic logic [2:0] idx_of(input logic [5:0] h);
    for (int i = 0; i < 6; i++) if (h[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(negedge clk);
    reg_we = 0; reg_size = 2'b10;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    d = reg_rdata;
  endtask

  // returns {hit, err, idx}
  task automatic access(input logic [31:0] a, input logic w, output logic [9:0] r);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    r = {cs_hit, bus_err, cs_idx};
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [9:0]  r;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 hit", {26'd0, cs_hit}, 0);
    chk("R1 err", {31'd0, bus_err}, 0);
    rd_reg(8'h00, d); chk("R1 base0", d, 0);
    rd_reg(8'h04, d); chk("R1 mask0", d, 0);
    rd_reg(8'h60, d); chk("R1 pmux", d, 0);

    access(32'h6000_1234, 1'b0, r); chk("R2 reset global", 32'(r), {6'h01, 1'b0, 3'd0});
    access(32'h1000_0000, 1'b0, r); chk("R7 global outside", 32'(r), 0);

    // window 1 enabled before window 0
    wr_reg(8'd12, 32'h6010_ABCD, 2'b10);
    wr_reg(8'd16, 32'h000F_0001, 2'b10);
    access(32'h6010_0000, 1'b1, r); chk("R2 window0 overrides", 32'(r), {6'h01, 1'b0, 3'd0});

    wr_reg(8'd0,  32'h7000_0000, 2'b10);
    wr_reg(8'd4,  32'h0000_0001, 2'b10);
    wr_reg(8'd24, 32'h6018_0000, 2'b10);
    wr_reg(8'd28, 32'h0000_0101, 2'b10);
    wr_reg(8'd36, 32'h8000_0000, 2'b10);
    wr_reg(8'd40, 32'h00FF_0101, 2'b10);
    wr_reg(8'd48, 32'h8000_0000, 2'b10);
    wr_reg(8'd52, 32'h0000_0001, 2'b10);
    wr_reg(8'd60, 32'h9000_0000, 2'b10);

    foreach (VECS[k]) begin
      access(VECS[k].addr, VECS[k].wr, r);
      chk($sformatf("R3/R5/R6/R11 vector %0d", k), 32'(r),
          32'({VECS[k].hit, VECS[k].err, idx_of(VECS[k].hit)}));
    end

    // R8 idle cycle after a hit
    access(32'h7000_0000, 1'b0, r);
    @(negedge clk);
    chk("R8 idle zero", {25'd0, cs_hit, bus_err}, 0);

    // R4 enabling window 5
    wr_reg(8'd64, 32'h0000_0001, 2'b10);
    access(32'h9000_0000, 1'b0, r); chk("R4 R11 window5", 32'(r), {6'h20, 1'b0, 3'd5});

    // R10 readback
    rd_reg(8'd12, d); chk("R10 base1 reserved zero", d, 32'h6010_0000);
    rd_reg(8'd40, d); chk("R10 mask3", d, 32'h00FF_0101);
    rd_reg(8'd20, d); chk("R10 ctrl1 reset", d, 32'h003F_FC00);
    wr_reg(8'd32, 32'h1234_5678, 2'b10);
    rd_reg(8'd32, d); chk("R10 ctrl2", d, 32'h1234_5678);

    // R9 multiplex register
    wr_reg(8'h60, 32'h1230_0000, 2'b10);
    chk("R9 good no err", {31'd0, reg_err}, 0);
    rd_reg(8'h60, d); chk("R9 stored", d, 32'h1230_0000);
    wr_reg(8'h60, 32'h4500_0001, 2'b10);
    chk("R9 reserved err", {31'd0, reg_err}, 1);
    rd_reg(8'h60, d); chk("R9 reserved unchanged", d, 32'h1230_0000);
    wr_reg(8'h60, 32'h4500_0000, 2'b01);
    chk("R9 size err", {31'd0, reg_err}, 1);
    rd_reg(8'h60, d); chk("R9 size unchanged", d, 32'h1230_0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule